// File: doc/BRIEF.md
# Dual-channel interval timer with interrupt status

A memory-mapped peripheral holding two independent interval counters, a free-running cycle counter and a small interrupt status block, all on a plain 32-bit register bus (byte address, write strobe, write data, combinational read data). Software writes a reload value into a channel, issues a load command through that channel's control register, then a run command. The channel counts from zero up to its limit, wraps back to zero and re-fetches the limit from the reload register, flagging one expiry per period.

Large limits are counted through a fixed prescaler of 2048 clocks, so a channel covers long intervals without a wide divider chain. Each expiry latches a raw status bit that software can mask, inspect in masked form and clear by writing ones to an acknowledge register. A single interrupt line is the OR of raw bits that are enabled by the mask. The clock-select field of each control register is stored and read back; codes 0 and 1 mean no clock reaches the counter, all other codes count on the block clock.

Top module: `duo_tick_timer`

## Requirements
- R1: After reset every register reads zero, both channels are stopped with zero count and zero limit, and `irq_o` is low.
- R2: Offset 0x38 reads a 32-bit counter that rises by one on every clock after reset and wraps from all-ones to zero.
- R3: Channel k (k = 0, 1) has its reload register at 0x10*k+0x00 and its control register at 0x10*k+0x08; a control read returns the clock code in bits [4:2] and the last command in bits [1:0].
- R4: Command 0 (load) copies the reload register into the active limit and clears count and prescaler without changing the run state; command 3 changes neither counter nor run state.
- R5: Command 2 makes a channel run, command 1 stops it; a stopped channel keeps its count, readable at 0x10*k+0x04.
- R6: A running channel with limit L <= 2048 advances by one per clock from 0 to L, then returns to 0 with a one-clock expiry, re-fetching its limit from the reload register (period L+1).
- R7: With limit L > 2048 the count advances once per 2048 clocks and its terminal value is L >> 11.
- R8: A running channel whose clock code is 0 or 1 holds its count; codes 2 to 7 count on the block clock.
- R9: An expiry of channel k sets raw bit k at 0x50 whatever the mask.
- R10: The mask at 0x48 keeps bits [1:0] of the last write (upper bits read zero); offset 0x54 reads raw AND mask.
- R11: Writing 0x4C clears each raw bit written as 1 and the offset reads zero; an expiry in the same clock as the clear of its bit leaves that bit set.
- R12: `irq_o` is high exactly when raw AND mask is non-zero, from the clock after the raw bit or mask register changes.
- R13: Any other offset reads zero and a write to it changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte offset of the accessed register |
| we_i | input | 1 | Write strobe, one write per clock |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Interrupt request, level |

## Verification
The collision that matters is an expiry and an acknowledge of the same raw bit landing in one clock; the bench provokes it by giving channel 0 a zero limit so it expires on every tick and then writing the acknowledge, and judges that the bit reads back set and the interrupt stays high. A second overlap is a load or stop command arriving in the clock a channel expires, where the command must win over the wrap while the expiry still reaches the status. Both are judged against a behavioural model that advances in step with the design and is compared on every clock while the read address cycles over the live registers.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    CMD_LOAD = 2'd0,
    CMD_STOP = 2'd1,
    CMD_RUN  = 2'd2,
    CMD_NOP  = 2'd3
  } tmr_cmd_e;

  localparam int unsigned CH_STRIDE  = 'h10;
  localparam int unsigned OFF_RELOAD = 'h00;
  localparam int unsigned OFF_DATA   = 'h04;
  localparam int unsigned OFF_CTRL   = 'h08;
  localparam int unsigned OFF_TIME   = 'h38;
  localparam int unsigned OFF_MASK   = 'h48;
  localparam int unsigned OFF_ACK    = 'h4C;
  localparam int unsigned OFF_RAW    = 'h50;
  localparam int unsigned OFF_MSKD   = 'h54;
endpackage

// File: rtl/tmr_free_counter.sv
module tmr_free_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] value_o
);
  logic [W-1:0] tm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tm_q <= '0;
    else         tm_q <= tm_q + 1'b1;
  end

  assign value_o = tm_q;

  assert_time_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> value_o == W'($past(value_o) + 1'b1));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned CODE_W   = 3,
  parameter int unsigned PRE_LOG2 = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reload_we_i,
  input  logic [CNT_W-1:0]  reload_wdata_i,
  input  logic              ctrl_we_i,
  input  logic [CODE_W+1:0] ctrl_wdata_i,
  output logic [CNT_W-1:0]  reload_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [CODE_W+1:0] ctrl_o,
  output logic              expire_o
);
  localparam logic [CNT_W-1:0] PRE_THR = CNT_W'(1) << PRE_LOG2;

  logic [CNT_W-1:0]    reload_q, lim_q, cnt_q, term;
  logic [PRE_LOG2-1:0] pre_q;
  logic [CODE_W-1:0]   code_q;
  tmr_cmd_e            cmd_q, cmd_in;
  logic                run_q, prescaled, clk_on, active, tick, load;

  assign cmd_in    = tmr_cmd_e'(ctrl_wdata_i[1:0]);
  assign load      = ctrl_we_i && cmd_in == CMD_LOAD;
  assign prescaled = lim_q > PRE_THR;
  assign term      = prescaled ? (lim_q >> PRE_LOG2) : lim_q;
  assign clk_on    = code_q > CODE_W'(1);
  assign active    = run_q && clk_on;
  assign tick      = active && (!prescaled || pre_q == '1);
  assign expire_o  = tick && cnt_q == term;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '0;
      lim_q    <= '0;
      cnt_q    <= '0;
      pre_q    <= '0;
      code_q   <= '0;
      cmd_q    <= CMD_LOAD;
      run_q    <= 1'b0;
    end else begin
      if (reload_we_i) reload_q <= reload_wdata_i;
      if (load)                       pre_q <= '0;
      else if (active && prescaled)   pre_q <= pre_q + 1'b1;
      if (load || expire_o)           cnt_q <= '0;
      else if (tick)                  cnt_q <= cnt_q + 1'b1;
      if (load || expire_o)           lim_q <= reload_q;
      if (ctrl_we_i) begin
        code_q <= ctrl_wdata_i[CODE_W+1:2];
        cmd_q  <= cmd_in;
        if (cmd_in == CMD_STOP)     run_q <= 1'b0;
        else if (cmd_in == CMD_RUN) run_q <= 1'b1;
      end
    end
  end

  assign reload_o = reload_q;
  assign count_o  = cnt_q;
  assign ctrl_o   = {code_q, cmd_q};

  assert_count_in_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= term);
  assert_wrap_to_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> cnt_q == '0);
  assert_stopped_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !ctrl_we_i) |=> $stable(cnt_q));
  assert_no_clock_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_q <= CODE_W'(1) && !ctrl_we_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl #(
  parameter int unsigned N_CH = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            mask_we_i,
  input  logic            ack_we_i,
  input  logic [N_CH-1:0] wdata_i,
  input  logic [N_CH-1:0] expire_i,
  output logic [N_CH-1:0] mask_o,
  output logic [N_CH-1:0] raw_o,
  output logic            irq_o
);
  logic [N_CH-1:0] mask_q, raw_q, clr;

  assign clr = ack_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      raw_q  <= '0;
    end else begin
      raw_q <= (raw_q & ~clr) | expire_i;
      if (mask_we_i) mask_q <= wdata_i;
    end
  end

  assign mask_o = mask_q;
  assign raw_o  = raw_q;
  assign irq_o  = |(raw_q & mask_q);

  // set wins over a same-cycle clear
  assert_expire_sets_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |expire_i |=> (raw_q & $past(expire_i)) == $past(expire_i));
  assert_ack_clears_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_we_i |=> (raw_q & $past(wdata_i) & ~$past(expire_i)) == '0);
  assert_quiet_irq_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !irq_o);
endmodule

// File: rtl/duo_tick_timer.sv
module duo_tick_timer
  import tmr_pkg::*;
#(
  parameter int unsigned N_CH     = 2,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CODE_W   = 3,
  parameter int unsigned PRE_LOG2 = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int unsigned CTRL_W = CODE_W + 2;

  logic [DATA_W-1:0] ch_reload [N_CH];
  logic [DATA_W-1:0] ch_count  [N_CH];
  logic [CTRL_W-1:0] ch_ctrl   [N_CH];
  logic [N_CH-1:0]   expire, mask, raw;
  logic [DATA_W-1:0] tm;

  tmr_free_counter #(.W(DATA_W)) u_time (
    .clk_i, .rst_ni, .value_o(tm)
  );

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_REL  = ADDR_W'(k*CH_STRIDE + OFF_RELOAD);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(k*CH_STRIDE + OFF_CTRL);
    tmr_channel #(.CNT_W(DATA_W), .CODE_W(CODE_W), .PRE_LOG2(PRE_LOG2)) u_ch (
      .clk_i,
      .rst_ni,
      .reload_we_i   (we_i && addr_i == A_REL),
      .reload_wdata_i(wdata_i),
      .ctrl_we_i     (we_i && addr_i == A_CTRL),
      .ctrl_wdata_i  (wdata_i[CTRL_W-1:0]),
      .reload_o      (ch_reload[k]),
      .count_o       (ch_count[k]),
      .ctrl_o        (ch_ctrl[k]),
      .expire_o      (expire[k])
    );
  end

  tmr_irq_ctrl #(.N_CH(N_CH)) u_irq (
    .clk_i,
    .rst_ni,
    .mask_we_i(we_i && addr_i == ADDR_W'(OFF_MASK)),
    .ack_we_i (we_i && addr_i == ADDR_W'(OFF_ACK)),
    .wdata_i  (wdata_i[N_CH-1:0]),
    .expire_i (expire),
    .mask_o   (mask),
    .raw_o    (raw),
    .irq_o    (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < N_CH; k++) begin
      if (addr_i == ADDR_W'(k*CH_STRIDE + OFF_RELOAD)) rdata_o = ch_reload[k];
      if (addr_i == ADDR_W'(k*CH_STRIDE + OFF_DATA))   rdata_o = ch_count[k];
      if (addr_i == ADDR_W'(k*CH_STRIDE + OFF_CTRL))   rdata_o = DATA_W'(ch_ctrl[k]);
    end
    if (addr_i == ADDR_W'(OFF_TIME)) rdata_o = tm;
    if (addr_i == ADDR_W'(OFF_MASK)) rdata_o = DATA_W'(mask);
    if (addr_i == ADDR_W'(OFF_RAW))  rdata_o = DATA_W'(raw);
    if (addr_i == ADDR_W'(OFF_MSKD)) rdata_o = DATA_W'(raw & mask);
  end

  assert_ack_reads_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == ADDR_W'(OFF_ACK) |-> rdata_o == '0);
  assert_irq_follows_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> raw != '0 && mask != '0);
endmodule

// File: tb/duo_tick_timer_tb_top.sv
`timescale 1ns/1ps
module duo_tick_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string phase = "R1";

  always #4 clk = ~clk;

  duo_tick_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference
  logic [31:0] m_rel [2], m_lim [2], m_cnt [2];
  int          m_pre [2], m_code [2], m_cmd [2];
  bit          m_run [2];
  logic [1:0]  m_mask, m_raw;
  logic [31:0] m_tm;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_rel[c] = 0; m_lim[c] = 0; m_cnt[c] = 0;
        m_pre[c] = 0; m_code[c] = 0; m_cmd[c] = 0; m_run[c] = 0;
      end
      m_mask = 0; m_raw = 0; m_tm = 0;
    end else begin
      logic [1:0] exp, ack;
      exp = 0;
      for (int c = 0; c < 2; c++) begin
        logic [31:0] term;
        bit act, tk, big;
        big  = m_lim[c] > 2048;
        term = big ? (m_lim[c] >> 11) : m_lim[c];
        act  = m_run[c] && m_code[c] >= 2;
        tk   = act && (!big || m_pre[c] == 2047);
        if (act && big) m_pre[c] = (m_pre[c] + 1) % 2048;
        if (tk) begin
          if (m_cnt[c] == term) begin
            m_cnt[c] = 0; m_lim[c] = m_rel[c]; exp[c] = 1'b1;
          end else m_cnt[c] = m_cnt[c] + 1;
        end
        if (we && addr == 8'(c*16)) m_rel[c] = wdata;
        if (we && addr == 8'(c*16 + 8)) begin
          m_code[c] = int'(wdata[4:2]);
          m_cmd[c]  = int'(wdata[1:0]);
          if (m_cmd[c] == 0) begin m_lim[c] = m_rel[c]; m_cnt[c] = 0; m_pre[c] = 0; end
          if (m_cmd[c] == 1) m_run[c] = 0;
          if (m_cmd[c] == 2) m_run[c] = 1;
        end
      end
      ack = (we && addr == 8'h4C) ? wdata[1:0] : 2'b00;
      m_raw = (m_raw & ~ack) | exp;
      if (we && addr == 8'h48) m_mask = wdata[1:0];
      m_tm = m_tm + 1;
    end
  end

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    for (int c = 0; c < 2; c++) begin
      if (a == 8'(c*16))     return m_rel[c];
      if (a == 8'(c*16 + 4)) return m_cnt[c];
      if (a == 8'(c*16 + 8)) return 32'(m_code[c] * 4 + m_cmd[c]);
    end
    case (a)
      8'h38: return m_tm;
      8'h48: return 32'(m_mask);
      8'h50: return 32'(m_raw);
      8'h54: return 32'(m_raw & m_mask);
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    #2;
    if (!done) begin
      n_cmp++;
      if (rdata !== exp_rd(addr)) begin
        n_bad++;
        $display("FAIL %s rdata @%02h actual %08h expected %08h", phase, addr, rdata, exp_rd(addr));
      end
      n_cmp++;
      if (irq !== |(m_raw & m_mask)) begin
        n_bad++;
        $display("FAIL %s/R12 irq actual %0b expected %0b", phase, irq, |(m_raw & m_mask));
      end
    end
  end

  logic [7:0] polls [12] = '{8'h04, 8'h14, 8'h50, 8'h54, 8'h38, 8'h48,
                             8'h08, 8'h00, 8'h18, 8'h10, 8'h4C, 8'h3C};
  int poll_i = 0;

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      we = 1'b0; addr = polls[poll_i]; poll_i = (poll_i + 1) % 12;
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  function automatic logic [31:0] ctl(input int code, input int cmd);
    return 32'(code * 4 + cmd);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    phase = "R1"; idle(6);
    rst_n = 1'b1;
    phase = "R1"; idle(14);
    phase = "R2"; idle(6);
    phase = "R3"; wr(8'h00, 5); wr(8'h10, 3); wr(8'h08, ctl(5, 3)); idle(12);
    phase = "R13"; wr(8'h3C, 32'hFFFF_FFFF); wr(8'h20, 7); wr(8'h0C, 9); wr(8'h58, 1); idle(12);
    phase = "R4"; wr(8'h08, ctl(5, 0)); wr(8'h18, ctl(4, 0)); idle(12);
    phase = "R6"; wr(8'h08, ctl(5, 2)); wr(8'h18, ctl(6, 2)); idle(36);
    phase = "R9"; idle(12);
    phase = "R10"; wr(8'h48, 32'hFFFF_FFFD); idle(12); wr(8'h48, 32'h3); idle(12);
    phase = "R11"; wr(8'h4C, 1); idle(3); wr(8'h4C, 3); idle(12);
    phase = "R6"; wr(8'h10, 6); idle(30);
    phase = "R11"; wr(8'h00, 0); wr(8'h08, ctl(7, 0)); idle(4);
    wr(8'h4C, 1); idle(2); wr(8'h4C, 3); idle(12);
    phase = "R4"; wr(8'h08, ctl(7, 3)); idle(6); wr(8'h18, ctl(6, 0)); idle(8);
    phase = "R5"; wr(8'h00, 9); wr(8'h08, ctl(7, 0)); idle(5); wr(8'h08, ctl(7, 1)); idle(24);
    phase = "R8"; wr(8'h18, ctl(1, 2)); idle(20); wr(8'h18, ctl(0, 2)); idle(12);
    wr(8'h18, ctl(2, 2)); idle(20); wr(8'h18, ctl(7, 1)); idle(6);
    phase = "R7"; wr(8'h4C, 3); wr(8'h00, 2049); wr(8'h08, ctl(5, 0)); wr(8'h08, ctl(5, 2)); idle(9000);
    wr(8'h00, 4096); wr(8'h08, ctl(5, 0)); idle(13000);
    wr(8'h00, 2048); wr(8'h08, ctl(5, 0)); idle(6200);
    phase = "R12"; wr(8'h48, 0); idle(8); wr(8'h4C, 3); wr(8'h48, 1); idle(8);
    phase = "R1"; rst_n = 1'b0; idle(6); rst_n = 1'b1; idle(10);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not end, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule